// File: doc/BRIEF.md
# Switchable Victim-Way Selector

This unit decides which way of a set an N-way set-associative (or fully associative) cache should evict next. A two-bit mode input selects one of four selection rules at run time: recency order, oldest fill, fewest references, or a pseudo-random draw. The cache controller reports every reference (a hit) and every line fill to the unit. The controller also presents the set it is about to fill, together with the valid bits of that set's lines. The unit answers with a victim way index.

The unit keeps the state of all four rules for every set, whichever rule is currently selected, so the mode can change between any two cycles without losing history. With two ways, recency is held as one use bit per line. With more ways, it is held as an ordered list of way numbers. With a single way the unit holds no state and always answers way 0. Tag comparison, data arrays and memory traffic stay in the surrounding cache.

The reference and fill strobes are plain single-cycle pulses that are always accepted, and the unit never applies back-pressure. The victim is a combinational function of the query inputs and the stored state, so the controller may sample it in the same cycle it presents the query.

Top module: `repl_unit`

## Requirements
- R1: With WAYS = 1 the victim is always 0, whatever the inputs.
- R2: The victim follows the query set, the mode and the valid mask in the same cycle. A reference or fill changes the victim from the next clock edge on.
- R3: With WAYS = 2 in mode 0, a reference or fill of way w sets that line's use bit to 1 and clears the other line's use bit. The victim is the lowest way whose use bit is 0.
- R4: With WAYS > 2 in mode 0, each set keeps a list of way numbers. A referenced or filled way moves to the front of the list, and the victim is the way at the back.
- R5: In mode 1, each set keeps a pointer that is the victim. Every fill to that set advances the pointer by one, wrapping from WAYS-1 to 0, whichever way was filled.
- R6: In mode 2, each line keeps a CNT_W-bit reference count. A reference increments the count until it holds at its maximum, and a fill clears it to 0. The victim is the way with the smallest count, and on a tie the lowest way wins.
- R7: In mode 3, the victim is a free-running 16-bit LFSR taken modulo WAYS. The LFSR is seeded with 0xACE1 at reset and shifts left every clock, feeding in the XOR of bits 15, 13, 12 and 10.
- R8: If any bit of the valid mask is 0, the victim is the lowest way whose valid bit is 0, in every mode.
- R9: After reset, the recency list of every set holds way i at position i (victim WAYS-1), all use bits and counts are 0, and all FIFO pointers are 0.
- R10: When a reference and a fill name the same set in one cycle, the reference is dropped and only the fill is applied.
- R11: The state of all four modes is updated on every strobe, regardless of which mode is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Mode: 0 recency, 1 oldest fill, 2 fewest references, 3 random |
| acc_en | input | 1 | Reference strobe |
| acc_set | input | SET_W | Set of the reference |
| acc_way | input | WAY_W | Way of the reference |
| fill_en | input | 1 | Fill strobe |
| fill_set | input | SET_W | Set being filled |
| fill_way | input | WAY_W | Way being filled |
| q_set | input | SET_W | Set whose victim is requested |
| q_valid | input | WAYS | Valid bits of the lines of q_set |
| victim | output | WAY_W | Selected way |

## Verification
A corrupted recency list, use bit, count or pointer shows up at the victim port as soon as that set is queried in the matching mode, which can be one cycle after the faulty update. The comparison runs every cycle on randomly chosen sets and modes, so a bad state is normally exposed within a few cycles. Errors in the mode that is not selected stay hidden until the mode switches, so the bench changes mode nearly every cycle. An LFSR step error diverges at once and never heals.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_LFU  = 2'd2,
    POL_RAND = 2'd3
  } policy_e;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/repl_recency.sv
module repl_recency #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [SET_W-1:0] a_set,
  input  logic [WAY_W-1:0] a_way,
  input  logic             b_en,
  input  logic [SET_W-1:0] b_set,
  input  logic [WAY_W-1:0] b_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_victim
);
  if (WAYS == 2) begin : g_use
    // one use bit per line; the referenced line holds the 1
    logic [1:0] use_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) use_q[s] <= 2'b00;
      end else begin
        for (int s = 0; s < SETS; s++) begin
          if (a_en && a_set == SET_W'(s))      use_q[s] <= 2'b01 << a_way;
          else if (b_en && b_set == SET_W'(s)) use_q[s] <= 2'b01 << b_way;
        end
      end
    end

    assign rd_victim = use_q[rd_set][0] ? WAY_W'(1) : WAY_W'(0);
  end else begin : g_list
    typedef logic [WAYS-1:0][WAY_W-1:0] order_t;
    order_t order_q [SETS];

    function automatic order_t to_front(order_t cur, logic [WAY_W-1:0] w);
      order_t nxt;
      logic   passed;
      passed = 1'b0;
      nxt[0] = w;
      for (int i = 1; i < WAYS; i++) begin
        if (cur[i-1] == w) passed = 1'b1;
        nxt[i] = passed ? cur[i] : cur[i-1];
      end
      return nxt;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++)
          for (int i = 0; i < WAYS; i++) order_q[s][i] <= WAY_W'(i);
      end else begin
        for (int s = 0; s < SETS; s++) begin
          if (a_en && a_set == SET_W'(s))      order_q[s] <= to_front(order_q[s], a_way);
          else if (b_en && b_set == SET_W'(s)) order_q[s] <= to_front(order_q[s], b_way);
        end
      end
    end

    assign rd_victim = order_q[rd_set][WAYS-1];
  end
endmodule

// File: rtl/repl_lfu.sv
module repl_lfu #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int CNT_W = 3,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [SET_W-1:0] inc_set,
  input  logic [WAY_W-1:0] inc_way,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_set,
  input  logic [WAY_W-1:0] clr_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] rd_victim
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WAYS-1:0][CNT_W-1:0] cnt_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (clr_en && clr_set == SET_W'(s) && clr_way == WAY_W'(w))
            cnt_q[s][w] <= '0;
          else if (inc_en && inc_set == SET_W'(s) && inc_way == WAY_W'(w)
                   && cnt_q[s][w] != CNT_MAX)
            cnt_q[s][w] <= cnt_q[s][w] + 1'b1;
        end
      end
    end
  end

  // strict less-than keeps the lowest way on ties
  always_comb begin
    logic [CNT_W-1:0] best;
    best      = cnt_q[rd_set][0];
    rd_victim = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (cnt_q[rd_set][w] < best) begin
        best      = cnt_q[rd_set][w];
        rd_victim = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/repl_lfsr.sv
module repl_lfsr
  import repl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LFSR_SEED;
    else        state <= {state[14:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
  end
endmodule

// File: rtl/repl_unit.sv
module repl_unit
  import repl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int CNT_W = 3,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policy,
  input  logic             acc_en,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fill_en,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [SET_W-1:0] q_set,
  input  logic [WAYS-1:0]  q_valid,
  output logic [WAY_W-1:0] victim
);
  if (WAYS == 1) begin : g_direct
    assign victim = '0;
  end else begin : g_assoc
    logic             acc_ok;
    logic [WAY_W-1:0] lru_v, lfu_v, rnd_v, pol_v;
    logic [15:0]      lfsr_q, lfsr_rem;
    logic [WAY_W-1:0] fifo_q [SETS];

    // a fill to the same set overrides a reference in that cycle
    assign acc_ok = acc_en && !(fill_en && fill_set == acc_set);

    repl_recency #(.WAYS(WAYS), .SETS(SETS)) u_rec (
      .clk(clk), .rst_n(rst_n),
      .a_en(acc_ok),   .a_set(acc_set),  .a_way(acc_way),
      .b_en(fill_en),  .b_set(fill_set), .b_way(fill_way),
      .rd_set(q_set),  .rd_victim(lru_v)
    );

    repl_lfu #(.WAYS(WAYS), .SETS(SETS), .CNT_W(CNT_W)) u_lfu (
      .clk(clk), .rst_n(rst_n),
      .inc_en(acc_ok),  .inc_set(acc_set),  .inc_way(acc_way),
      .clr_en(fill_en), .clr_set(fill_set), .clr_way(fill_way),
      .rd_set(q_set),   .rd_victim(lfu_v)
    );

    repl_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .state(lfsr_q));

    assign lfsr_rem = lfsr_q % 16'(WAYS);
    assign rnd_v    = lfsr_rem[WAY_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) fifo_q[s] <= '0;
      end else if (fill_en) begin
        fifo_q[fill_set] <= (fifo_q[fill_set] == WAY_W'(WAYS - 1)) ? '0
                            : fifo_q[fill_set] + 1'b1;
      end
    end

    always_comb begin
      case (policy_e'(policy))
        POL_LRU:  pol_v = lru_v;
        POL_FIFO: pol_v = fifo_q[q_set];
        POL_LFU:  pol_v = lfu_v;
        default:  pol_v = rnd_v;
      endcase
      victim = pol_v;
      // descending scan leaves the lowest empty way
      for (int w = WAYS - 1; w >= 0; w--)
        if (!q_valid[w]) victim = WAY_W'(w);
    end
  end
endmodule

module repl_unit_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       policy,
  input logic             acc_en,
  input logic [SET_W-1:0] acc_set,
  input logic [WAY_W-1:0] acc_way,
  input logic             fill_en,
  input logic [SET_W-1:0] fill_set,
  input logic [WAY_W-1:0] fill_way,
  input logic [SET_W-1:0] q_set,
  input logic [WAYS-1:0]  q_valid,
  input logic [WAY_W-1:0] victim
);
  if (WAYS == 1) begin : g_dm_chk
    a_r1_single_way: assert property (@(posedge clk) disable iff (!rst_n)
      victim == '0);
  end else begin : g_sa_chk
    a_r8_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
      (q_valid != '1) |-> !q_valid[victim]);

    a_r4_hit_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !fill_en && acc_set == q_set && policy == 2'd0 && q_valid == '1)
      |=> (q_set != $past(q_set) || policy != 2'd0 || q_valid != '1
           || victim != $past(acc_way)));

    a_r5_fifo_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_set == q_set && policy == 2'd1 && q_valid == '1)
      |=> (q_set != $past(q_set) || policy != 2'd1 || q_valid != '1
           || int'(victim) == (int'($past(victim)) + 1) % WAYS));

    a_r10_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && fill_en && acc_set == fill_set && fill_set == q_set
       && policy == 2'd0 && q_valid == '1)
      |=> (q_set != $past(q_set) || policy != 2'd0 || q_valid != '1
           || victim != $past(fill_way)));
  end
endmodule

bind repl_unit repl_unit_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (.*);

// File: tb/repl_unit_test.sv
module repl_unit_test;
  localparam int CLK_NS = 10;
  localparam int NCYC   = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] policy = '0;
  logic       acc_en = 1'b0, fill_en = 1'b0;
  logic [1:0] acc_set = '0, fill_set = '0, q_set = '0;
  logic [1:0] acc_way = '0, fill_way = '0;
  logic [3:0] q_valid = '1;
  logic [1:0] vic4;
  logic       vic2, vic1;

  int checks = 0, bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  repl_unit #(.WAYS(4), .SETS(4), .CNT_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
    .q_set(q_set), .q_valid(q_valid), .victim(vic4));

  repl_unit #(.WAYS(2), .SETS(4), .CNT_W(2)) uut_two (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .acc_en(acc_en), .acc_set(acc_set), .acc_way(acc_way[0:0]),
    .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way[0:0]),
    .q_set(q_set), .q_valid(q_valid[1:0]), .victim(vic2));

  repl_unit #(.WAYS(1), .SETS(2), .CNT_W(2)) uut_one (
    .clk(clk), .rst_n(rst_n), .policy(policy),
    .acc_en(acc_en), .acc_set(acc_set[0:0]), .acc_way(1'b0),
    .fill_en(fill_en), .fill_set(fill_set[0:0]), .fill_way(1'b0),
    .q_set(q_set[0:0]), .q_valid(q_valid[0:0]), .victim(vic1));

  // behavioural reference
  int          rec [4][$];
  int          use2 [4];
  int          cnt4 [4][4];
  int          cnt2 [4][2];
  int          ptr4 [4], ptr2 [4];
  logic [15:0] lf;

  task automatic touch(int s, int w);
    for (int i = 0; i < rec[s].size(); i++)
      if (rec[s][i] == w) begin rec[s].delete(i); break; end
    rec[s].push_front(w);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) begin
        rec[s] = {0, 1, 2, 3};
        use2[s] = 0; ptr4[s] = 0; ptr2[s] = 0;
        for (int w = 0; w < 4; w++) cnt4[s][w] = 0;
        for (int w = 0; w < 2; w++) cnt2[s][w] = 0;
      end
      lf = 16'hACE1;
    end else begin
      bit ok;
      ok = acc_en && !(fill_en && fill_set == acc_set);
      if (ok) begin
        touch(acc_set, acc_way);
        use2[acc_set] = 1 << acc_way[0];
        if (cnt4[acc_set][acc_way] < 3) cnt4[acc_set][acc_way]++;
        if (cnt2[acc_set][acc_way[0]] < 3) cnt2[acc_set][acc_way[0]]++;
      end
      if (fill_en) begin
        touch(fill_set, fill_way);
        use2[fill_set] = 1 << fill_way[0];
        cnt4[fill_set][fill_way] = 0;
        cnt2[fill_set][fill_way[0]] = 0;
        ptr4[fill_set] = (ptr4[fill_set] + 1) % 4;
        ptr2[fill_set] = (ptr2[fill_set] + 1) % 2;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
  end

  function automatic int expect_v(int nw, int s, int pol, logic [3:0] vm);
    int best;
    if (nw == 1) return 0;
    for (int w = 0; w < nw; w++) if (!vm[w]) return w;
    case (pol)
      0: return (nw == 2) ? (use2[s] & 1) : rec[s][rec[s].size() - 1];
      1: return (nw == 2) ? ptr2[s] : ptr4[s];
      2: begin
        best = 0;
        for (int w = 1; w < nw; w++)
          if ((nw == 2 ? cnt2[s][w] : cnt4[s][w]) < (nw == 2 ? cnt2[s][best] : cnt4[s][best]))
            best = w;
        return best;
      end
      default: return int'(lf % 16'(nw));
    endcase
  endfunction

  function automatic string tag_of(int nw, int pol, logic [3:0] vm);
    logic [3:0] m;
    if (nw == 1) return "R1";
    m = (nw == 2) ? (vm | 4'b1100) : vm;
    if (m != 4'hF) return "R8";
    case (pol)
      0: return (nw == 2) ? "R3" : "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_one(int nw, int got, string extra);
    int    exp;
    string t;
    exp = expect_v(nw, q_set, policy, q_valid);
    t   = tag_of(nw, policy, q_valid);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s%s R2 ways=%0d set=%0d mode=%0d: victim=%0d expected=%0d",
               t, extra, nw, q_set, policy, got, exp);
    end
  endtask

  task automatic check_all(string extra);
    check_one(4, int'(vic4), extra);
    check_one(2, int'(vic2), extra);
    check_one(1, int'(vic1), extra);
  endtask

  initial begin
    bit prev_col;
    logic [1:0] prev_pol;
    prev_col = 0;
    prev_pol = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, every mode with all lines valid
    for (int p = 0; p < 4; p++) begin
      policy = 2'(p);
      #1 check_all(" R9");
    end
    for (int c = 0; c < NCYC; c++) begin
      string ex;
      @(negedge clk);
      prev_col = acc_en && fill_en && acc_set == fill_set;
      prev_pol = policy;
      policy   = 2'($urandom_range(0, 3));
      acc_en   = ($urandom_range(0, 1) == 1);
      acc_set  = 2'($urandom_range(0, 3));
      acc_way  = 2'($urandom_range(0, 3));
      fill_en  = ($urandom_range(0, 9) < 3);
      fill_set = (c % 7 == 0) ? acc_set : 2'($urandom_range(0, 3));
      fill_way = 2'($urandom_range(0, 3));
      q_set    = (c % 3 == 0) ? acc_set : 2'($urandom_range(0, 3));
      q_valid  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      #1;
      ex = "";
      if (prev_col) ex = {ex, " R10"};
      if (policy != prev_pol) ex = {ex, " R11"};
      check_all(ex);
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule